// File: doc/BRIEF.md
# Multi-Mode Timer with Capture and Delta-Sigma Output

This block is a general-purpose timer/counter. Its count ticks come from the system clock divided by a power-of-two prescaler, or from edges of an external input, on the rising or the falling edge as selected. A small register port lets software load two compare values (High and Low), choose one of five modes, set the prescale and edge polarity, and enable two interrupt sources. The block drives one output pin and one interrupt line.

The compare modes produce a repeating mark-space waveform (PWM), a single period that then stops, or the same waveform clocked by external edges (counter mode). Capture mode times an incoming pulse: the count of ticks since capture started is stored in High at the pulse's rising edge and in Low at its falling edge. Delta-sigma mode spreads a programmed number of ones evenly over a fixed cycle of slots, in non-return-to-zero form or in return-to-zero form, where each slot is followed by a forced low slot.

Register map (word address on `addr`): 0 control, 1 High, 2 Low, 3 flags (write one to clear), 4 live count (read only). Control bits: [0] run, [3:1] mode (0 PWM, 1 single-shot, 2 capture, 3 counter, 4 delta-sigma), [4] external edge polarity (0 rising, 1 falling), [5] return-to-zero form, [6] rise interrupt enable, [7] period interrupt enable, [11:8] prescale exponent p. Flag bits: [0] rise, [1] period.

Top module: `mode_timer`

## Requirements
- R1: After reset every readable register (addresses 0 to 4) reads zero, and `timOut` and `irqOut` are low.
- R2: With exponent p in control bits [11:8], internal ticks occur every 2^p clocks; in PWM mode the first period flag appears at the High*2^p-th clock edge after the edge that set run.
- R3: In PWM mode (mode 0, prescale 1) with 1 <= Low < High, the period is High ticks and `timOut` is high for High-Low ticks of it: it rises on the tick where the count reaches Low and falls, with the count returning to zero, on the tick where it reaches High; with Low >= High it stays low.
- R4: In single-shot mode (mode 1) the block runs one period, then clears control bit 0 itself, leaving the count at zero and `timOut` low.
- R5: In counter mode (mode 3) each edge of `extIn` of the polarity in control bit 4 (0 rising, 1 falling) advances the count by one, after a two-flop synchroniser; the count wraps to zero on reaching High.
- R6: In capture mode (mode 2, prescale 1), if `capIn` rises just before the k-th clock edge after the start edge, High reads k+1; a fall just before the j-th edge makes Low read j+1, so Low minus High equals the pulse width in clocks.
- R7: In delta-sigma mode (mode 4, control bit 5 clear) with N = Low bits [4:0], 0 <= N <= 16, each run of 16 ticks from start holds exactly N high output ticks.
- R8: In delta-sigma mode with control bit 5 set, each run of 32 ticks holds exactly N high ticks and no two adjacent ticks are both high.
- R9: Flag bit 0 is set at the rise compare point only when control bit 6 is set, flag bit 1 at the period point only when control bit 7 is set, and `irqOut` is high whenever either flag is set.
- R10: Writing address 3 clears exactly the flag bits written as one; flags otherwise hold.
- R11: One clock after run is cleared the count reads zero and `timOut` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register word address for reads and writes |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for `addr`, combinational |
| extIn | input | 1 | External count input |
| capIn | input | 1 | Capture input |
| timOut | output | 1 | Timer output pin |
| irqOut | output | 1 | Interrupt request, OR of the flags |

## Verification
A register write lands on the clock edge that samples it, so a run starts on that edge and the first internal tick is the next edge (or the 2^p-th with prescale); output and flag changes become visible right after the tick edge that causes them. External and capture inputs take two synchroniser edges plus one edge-detect edge, which is why a capture rising before edge k stores k+1. The bench drives and samples only on falling clock edges and counts output-high samples over windows that are whole multiples of the expected cycle starting at the start edge, so every expected count follows arithmetically from High, Low, N and p without depending on phase.

// File: rtl/mode_timer_pkg.sv
package mode_timer_pkg;

  typedef enum logic [2:0] {
    MODE_PWM     = 3'd0,
    MODE_ONESHOT = 3'd1,
    MODE_CAPTURE = 3'd2,
    MODE_COUNT   = 3'd3,
    MODE_DSM     = 3'd4
  } tmr_mode_e;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_HIGH  = 3'd1;
  localparam logic [ADDR_W-1:0] A_LOW   = 3'd2;
  localparam logic [ADDR_W-1:0] A_FLAG  = 3'd3;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd4;

  // control field positions; prescale exponent starts at PRE_LSB
  localparam int B_RUN   = 0;
  localparam int B_FALL  = 4;
  localparam int B_RZ    = 5;
  localparam int B_RIE   = 6;
  localparam int B_PIE   = 7;
  localparam int PRE_LSB = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic      run;
    tmr_mode_e mode;
    logic      rzForm;
    logic      riseIrqEn;
    logic      perIrqEn;
    logic      tick;
    logic      capRise;
    logic      capFall;
    logic      wrHigh;
    logic      wrLow;
    logic [1:0] clrFlags;
  } tmr_strobe_t;

endpackage

// File: rtl/mode_timer_ctrl.sv
module mode_timer_ctrl
  import mode_timer_pkg::*;
#(
  parameter int PRE_W = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [PRE_LSB+PRE_W-1:0] wrCtrl,
  input  logic                   extIn,
  input  logic                   capIn,
  input  logic                   stopReq,
  output tmr_strobe_t            str,
  output logic [PRE_LSB+PRE_W-1:0] ctrlVal
);
  localparam int CTRL_W    = PRE_LSB + PRE_W;
  localparam int PRE_CNT_W = 1 << PRE_W;

  logic [CTRL_W-1:0]    ctrlReg;
  logic [PRE_CNT_W-1:0] preCnt, preMask;
  logic [PRE_W-1:0]     preExp;
  logic [1:0]           extSync, capSync;
  logic                 extPrev, capPrev;
  logic                 runBit, extEdge, preTick;
  tmr_mode_e            mode;

  assign runBit  = ctrlReg[B_RUN];
  assign mode    = tmr_mode_e'(ctrlReg[3:1]);
  assign preExp  = ctrlReg[PRE_LSB +: PRE_W];
  assign preMask = (PRE_CNT_W'(1) << preExp) - PRE_CNT_W'(1);
  assign preTick = (preCnt & preMask) == preMask;
  assign extEdge = ctrlReg[B_FALL] ? (extPrev & ~extSync[1]) : (~extPrev & extSync[1]);
  assign ctrlVal = ctrlReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      preCnt  <= '0;
      extSync <= '0;
      capSync <= '0;
      extPrev <= 1'b0;
      capPrev <= 1'b0;
    end else begin
      if (wrEn && addr == A_CTRL) ctrlReg <= wrCtrl;
      else if (stopReq)           ctrlReg[B_RUN] <= 1'b0;
      preCnt  <= runBit ? preCnt + PRE_CNT_W'(1) : '0;
      extSync <= {extSync[0], extIn};
      capSync <= {capSync[0], capIn};
      extPrev <= extSync[1];
      capPrev <= capSync[1];
    end
  end

  always_comb begin
    str           = '0;
    str.run       = runBit;
    str.mode      = mode;
    str.rzForm    = ctrlReg[B_RZ];
    str.riseIrqEn = ctrlReg[B_RIE];
    str.perIrqEn  = ctrlReg[B_PIE];
    str.tick      = runBit && ((mode == MODE_COUNT) ? extEdge : preTick);
    str.capRise   = runBit && mode == MODE_CAPTURE && capSync[1] && !capPrev;
    str.capFall   = runBit && mode == MODE_CAPTURE && !capSync[1] && capPrev;
    str.wrHigh    = wrEn && addr == A_HIGH;
    str.wrLow     = wrEn && addr == A_LOW;
    str.clrFlags  = (wrEn && addr == A_FLAG) ? wrCtrl[1:0] : 2'b00;
  end

  // R4
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopReq && !(wrEn && addr == A_CTRL) |=> !ctrlReg[B_RUN]);

  // R2
  pre_space_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.tick && !wrEn && mode != MODE_COUNT && preExp != '0 |=> !str.tick);

endmodule

// File: rtl/mode_timer_dp.sv
module mode_timer_dp
  import mode_timer_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DSM_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmr_strobe_t       str,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] highVal,
  output logic [DATA_W-1:0] lowVal,
  output logic [DATA_W-1:0] countVal,
  output logic [1:0]        flags,
  output logic              timOut,
  output logic              stopReq
);
  localparam int ACC_W = DSM_W + 1;

  logic [DATA_W-1:0] nextCount;
  logic [ACC_W-1:0]  accSum;
  logic [DSM_W-1:0]  acc;
  logic              dsPhase, cmpMode, hitHigh, hitLow;

  assign cmpMode   = str.mode inside {MODE_PWM, MODE_ONESHOT, MODE_COUNT};
  assign nextCount = countVal + DATA_W'(1);
  assign hitHigh   = str.tick && cmpMode && nextCount == highVal;
  assign hitLow    = str.tick && cmpMode && !hitHigh && nextCount == lowVal;
  assign stopReq   = hitHigh && str.mode == MODE_ONESHOT;
  assign accSum    = {1'b0, acc} + lowVal[DSM_W:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      highVal  <= '0;
      lowVal   <= '0;
      countVal <= '0;
      flags    <= '0;
      acc      <= '0;
      dsPhase  <= 1'b0;
      timOut   <= 1'b0;
    end else begin
      if (str.wrHigh)       highVal <= wrData;
      else if (str.capRise) highVal <= countVal;
      if (str.wrLow)        lowVal  <= wrData;
      else if (str.capFall) lowVal  <= countVal;

      if (!str.run) begin
        countVal <= '0;
        acc      <= '0;
        dsPhase  <= 1'b0;
        timOut   <= 1'b0;
      end else if (str.tick) begin
        if (str.mode == MODE_DSM) begin
          countVal <= nextCount;
          if (!str.rzForm || !dsPhase) begin
            acc    <= accSum[DSM_W-1:0];
            timOut <= accSum[DSM_W];
          end else begin
            timOut <= 1'b0;
          end
          dsPhase <= str.rzForm & ~dsPhase;
        end else if (cmpMode) begin
          if (hitHigh) begin
            countVal <= '0;
            timOut   <= 1'b0;
          end else begin
            countVal <= nextCount;
            if (hitLow) timOut <= 1'b1;
          end
        end else begin
          countVal <= nextCount;
          timOut   <= 1'b0;
        end
      end

      flags[0] <= (flags[0] & ~str.clrFlags[0]) | (hitLow & str.riseIrqEn);
      flags[1] <= (flags[1] & ~str.clrFlags[1]) | (hitHigh & str.perIrqEn);
    end
  end

  // R10
  rise_flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    flags[0] && !str.clrFlags[0] |=> flags[0]);

  // R10
  per_flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    flags[1] && !str.clrFlags[1] |=> flags[1]);

  // R11
  idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !str.run |=> !timOut && countVal == '0);

  // R8
  rz_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.run && str.mode == MODE_DSM && str.rzForm && str.tick && timOut |=> !timOut);

endmodule

// File: rtl/mode_timer.sv
module mode_timer
  import mode_timer_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PRE_W  = 4,
  parameter int DSM_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              extIn,
  input  logic              capIn,
  output logic              timOut,
  output logic              irqOut
);
  localparam int CTRL_W = PRE_LSB + PRE_W;

  tmr_strobe_t       str;
  logic [CTRL_W-1:0] ctrlVal;
  logic [DATA_W-1:0] highVal, lowVal, countVal;
  logic [1:0]        flags;
  logic              stopReq;

  mode_timer_ctrl #(.PRE_W(PRE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrCtrl(wrData[CTRL_W-1:0]), .extIn(extIn), .capIn(capIn),
    .stopReq(stopReq), .str(str), .ctrlVal(ctrlVal)
  );

  mode_timer_dp #(.DATA_W(DATA_W), .DSM_W(DSM_W)) u_dp (
    .clk(clk), .rstN(rstN), .str(str), .wrData(wrData),
    .highVal(highVal), .lowVal(lowVal), .countVal(countVal),
    .flags(flags), .timOut(timOut), .stopReq(stopReq)
  );

  assign irqOut = |flags;

  always_comb begin
    case (addr)
      A_CTRL:  rdData = DATA_W'(ctrlVal);
      A_HIGH:  rdData = highVal;
      A_LOW:   rdData = lowVal;
      A_FLAG:  rdData = DATA_W'(flags);
      A_COUNT: rdData = countVal;
      default: rdData = '0;
    endcase
  end

endmodule

// File: tb/mode_timer_bench.sv
`timescale 1ns/1ps
module mode_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        extIn = 1'b0;
  logic        capIn = 1'b0;
  logic        timOut, irqOut;
  int nChecks = 0;
  int nFail = 0;

  mode_timer u_mode_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .extIn(extIn), .capIn(capIn), .timOut(timOut), .irqOut(irqOut)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output int v);
    addr = a;
    #1;
    v = int'(rdData);
  endtask

  function automatic logic [15:0] cw(int run, int mode, int fall, int rz, int rie, int pie, int pexp);
    return 16'(run | (mode << 1) | (fall << 4) | (rz << 5) | (rie << 6) | (pie << 7) | (pexp << 8));
  endfunction

  task automatic stopAndClear();
    busWrite(3'd0, 16'd0);
    busWrite(3'd3, 16'd3);
  endtask

  // counts high samples over n cycles, also adjacent high pairs
  task automatic countHigh(input int n, output int highs, output int pairs);
    int prev = 0;
    highs = 0; pairs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (timOut) begin highs++; if (prev != 0) pairs++; end
      prev = int'(timOut);
    end
  endtask

  task automatic pulseExt(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); extIn = 1'b1;
      repeat (3) @(negedge clk);
      extIn = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    int v, highs, pairs;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      busRead(3'(a), v);
      chk($sformatf("R1 reg %0d after reset", a), v, 0);
    end
    chk("R1 timOut after reset", int'(timOut), 0);
    chk("R1 irqOut after reset", int'(irqOut), 0);

    // R3 / R9 PWM sweep
    for (int hi = 2; hi <= 7; hi++) begin
      for (int lo = 1; lo <= hi + 1; lo++) begin
        stopAndClear();
        busWrite(3'd1, 16'(hi));
        busWrite(3'd2, 16'(lo));
        busWrite(3'd0, cw(1, 0, 0, 0, 1, 1, 0));
        countHigh(3 * hi, highs, pairs);
        chk($sformatf("R3 pwm hi=%0d lo=%0d high ticks", hi, lo), highs, (lo < hi) ? 3 * (hi - lo) : 0);
        busRead(3'd3, v);
        chk($sformatf("R9 pwm hi=%0d lo=%0d flags", hi, lo), v, (lo < hi) ? 3 : 2);
        chk("R9 irqOut with flags", int'(irqOut), 1);
      end
    end

    // R9 enables
    for (int en = 0; en < 4; en++) begin
      stopAndClear();
      busWrite(3'd1, 16'd4);
      busWrite(3'd2, 16'd2);
      busWrite(3'd0, cw(1, 0, 0, 0, en & 1, en >> 1, 0));
      repeat (9) @(negedge clk);
      busRead(3'd3, v);
      chk($sformatf("R9 enables=%0d flags", en), v, en);
      chk($sformatf("R9 enables=%0d irqOut", en), int'(irqOut), (en != 0) ? 1 : 0);
    end

    // R10 write one to clear, run stopped so nothing sets
    busWrite(3'd0, 16'd0);
    busRead(3'd3, v);
    chk("R10 both flags before clear", v, 3);
    busWrite(3'd3, 16'd1);
    busRead(3'd3, v);
    chk("R10 clear bit0 only", v, 2);
    busWrite(3'd3, 16'd0);
    busRead(3'd3, v);
    chk("R10 write zero keeps flags", v, 2);
    busWrite(3'd3, 16'd2);
    busRead(3'd3, v);
    chk("R10 clear bit1", v, 0);
    chk("R10 irqOut cleared", int'(irqOut), 0);

    // R2 prescale: period flag at edge hi*2^p
    for (int p = 0; p < 4; p++) begin
      stopAndClear();
      busWrite(3'd1, 16'd3);
      busWrite(3'd2, 16'd1);
      busWrite(3'd0, cw(1, 0, 0, 0, 0, 1, p));
      repeat (3 * (1 << p) - 1) @(negedge clk);
      busRead(3'd3, v);
      chk($sformatf("R2 p=%0d flag one edge early", p), v, 0);
      @(negedge clk);
      busRead(3'd3, v);
      chk($sformatf("R2 p=%0d flag on time", p), v, 2);
    end

    // R4 single shot
    stopAndClear();
    busWrite(3'd1, 16'd5);
    busWrite(3'd2, 16'd2);
    busWrite(3'd0, cw(1, 1, 0, 0, 0, 1, 0));
    countHigh(20, highs, pairs);
    chk("R4 one-shot high ticks", highs, 3);
    busRead(3'd0, v);
    chk("R4 run bit cleared", v & 1, 0);
    busRead(3'd4, v);
    chk("R4 count parked", v, 0);
    busRead(3'd3, v);
    chk("R4 single period flag", v, 2);

    // R5 counter mode, rising edges
    stopAndClear();
    busWrite(3'd1, 16'd100);
    busWrite(3'd2, 16'd50);
    busWrite(3'd0, cw(1, 3, 0, 0, 0, 0, 0));
    pulseExt(5);
    repeat (4) @(negedge clk);
    busRead(3'd4, v);
    chk("R5 rising edges counted", v, 5);
    // R5 wrap at High
    stopAndClear();
    busWrite(3'd1, 16'd3);
    busWrite(3'd0, cw(1, 3, 0, 0, 0, 1, 0));
    pulseExt(7);
    repeat (4) @(negedge clk);
    busRead(3'd4, v);
    chk("R5 count wraps at High", v, 1);
    busRead(3'd3, v);
    chk("R5 period flag on wrap", v, 2);
    // R5 falling polarity
    stopAndClear();
    busWrite(3'd1, 16'd100);
    busWrite(3'd0, cw(1, 3, 1, 0, 0, 0, 0));
    @(negedge clk); extIn = 1'b1;
    repeat (6) @(negedge clk);
    busRead(3'd4, v);
    chk("R5 falling select ignores rise", v, 0);
    extIn = 1'b0;
    repeat (6) @(negedge clk);
    busRead(3'd4, v);
    chk("R5 falling select counts fall", v, 1);

    // R6 capture sweep
    for (int r = 0; r < 4; r++) begin
      for (int w = 1; w < 5; w++) begin
        stopAndClear();
        capIn = 1'b0;
        busWrite(3'd0, cw(1, 2, 0, 0, 0, 0, 0));
        repeat (r) @(negedge clk);
        capIn = 1'b1;
        repeat (w) @(negedge clk);
        capIn = 1'b0;
        repeat (5) @(negedge clk);
        busRead(3'd1, v);
        chk($sformatf("R6 r=%0d w=%0d High", r, w), v, r + 2);
        busRead(3'd2, v);
        chk($sformatf("R6 r=%0d w=%0d Low", r, w), v, r + w + 2);
      end
    end

    // R7 / R8 delta-sigma sweep
    for (int n = 0; n <= 16; n++) begin
      stopAndClear();
      busWrite(3'd2, 16'(n));
      busWrite(3'd0, cw(1, 4, 0, 0, 0, 0, 0));
      countHigh(32, highs, pairs);
      chk($sformatf("R7 nrz n=%0d ones in 32", n), highs, 2 * n);
      stopAndClear();
      busWrite(3'd0, cw(1, 4, 0, 1, 0, 0, 0));
      countHigh(32, highs, pairs);
      chk($sformatf("R8 rz n=%0d ones in 32", n), highs, n);
      chk($sformatf("R8 rz n=%0d adjacent highs", n), pairs, 0);
    end

    // R11 stop clears count and output
    stopAndClear();
    busWrite(3'd1, 16'd10);
    busWrite(3'd2, 16'd2);
    busWrite(3'd0, cw(1, 0, 0, 0, 0, 0, 0));
    repeat (5) @(negedge clk);
    chk("R11 output high before stop", int'(timOut), 1);
    busWrite(3'd0, 16'd0);
    @(negedge clk);
    chk("R11 output low after stop", int'(timOut), 0);
    busRead(3'd4, v);
    chk("R11 count zero after stop", v, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule